// File: doc/BRIEF.md
# Operand-Pair Quotient Cache

This block remembers finished division results so that a repeated division can skip the divider. Each entry is keyed by the full pair of significands: the 52-bit dividend mantissa and the 52-bit divisor mantissa, with the leading one left implicit. The stored value is the 55-bit quotient mantissa, which includes guard, round and sticky bits so that later rounding can still be done correctly. The cache needs both operands of a division to match. It returns the finished quotient, not a reciprocal, so it can sit beside a divider of any kind.

The cache is probed in the same cycle that a division is issued, while the divider starts in parallel. The answer appears on the response outputs one cycle later. On a hit, the issuing logic takes the stored quotient and does not need the divider's result. On a miss, it waits for the divider and then presents the finished quotient on the fill port, and the cache stores it.

The cache is fully associative, with `ENTRIES` entries (128 by default). A fill whose key is already present is rewritten in place. Otherwise a fill takes the lowest-numbered empty entry. When no entry is empty, the fill evicts the entry under a round-robin pointer. A flush input empties the whole cache in one cycle.

The response path is a two-state machine:
- `RSP_IDLE` means no answer is being shown.
- `RSP_SHOW` means the result of the previous cycle's lookup is on the outputs.
- The transition *probe* (any state to `RSP_SHOW`) happens when `lk_valid` is high.
- The transition *quiet* (any state to `RSP_IDLE`) happens when `lk_valid` is low.

Each fill is classified as one of four kinds:
- `FILL_NONE`: no fill, or the fill is cancelled by a flush.
- `FILL_UPDATE`: the key is already present.
- `FILL_NEW`: an empty entry exists.
- `FILL_EVICT`: the cache is full.

Top module: `pairq_cache`

## Requirements
- R1: A lookup started with `lk_valid` high at a clock edge is answered at the next edge. `resp_valid` is high for exactly that one cycle, and it is low in any cycle that follows a cycle without a lookup.
- R2: A lookup reports `resp_hit`=1 and returns the stored quotient only when both the dividend mantissa and the divisor mantissa equal those of a valid entry. A match on only one of the two operands is a miss.
- R3: A lookup that misses reports `resp_hit`=0 with `resp_valid`=1, and `resp_quot` is all zeros.
- R4: A fill takes effect at its clock edge. Lookups started in later cycles see it. A lookup in the same cycle as the fill sees the contents from before the fill.
- R5: A fill whose key is already stored overwrites that entry's quotient in place. It creates no duplicate, uses no empty entry and does not move the round-robin pointer.
- R6: A fill with a new key goes into the lowest-numbered empty entry while one exists.
- R7: A fill with a new key into a full cache replaces the entry at the round-robin pointer, then advances the pointer by one and wraps from `ENTRIES`-1 to 0. The pointer starts at 0 after reset, and a flush does not move it.
- R8: A flush marks every entry empty. A fill in the same cycle as a flush is discarded. A lookup in the same cycle as a flush, or in the cycle after it, misses.
- R9: After reset the cache is empty and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Start a lookup this cycle |
| lk_dividend | input | MANT_W | Dividend mantissa of the lookup |
| lk_divisor | input | MANT_W | Divisor mantissa of the lookup |
| fill_valid | input | 1 | Store a finished quotient this cycle |
| fill_dividend | input | MANT_W | Dividend mantissa of the fill |
| fill_divisor | input | MANT_W | Divisor mantissa of the fill |
| fill_quot | input | QUO_W | Quotient mantissa with guard, round and sticky bits |
| resp_valid | output | 1 | Lookup answer present |
| resp_hit | output | 1 | Lookup found its operand pair |
| resp_quot | output | QUO_W | Stored quotient on a hit, zero on a miss |

## Verification
On every cycle, the assertions check:
- the one-cycle answer timing;
- that a miss outputs zeros;
- that at most one entry matches a key;
- that a flush gives misses in its own cycle and the next;
- that a fill followed at once by a lookup of the same pair hits with the filled quotient.

Some behaviours depend on many cycles of history and only the bench scenarios can show them:
- which entry is evicted in the end;
- that empty entries are used before eviction starts;
- that the pointer keeps its position across a flush;
- that in-place rewrites leave the pointer alone.

The bench shows these against a reference model, using directed fill sequences and a random mix drawn from a key pool larger than the cache.

// File: rtl/pairq_pkg.sv
package pairq_pkg;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_SHOW = 1'b1
    } rsp_state_e;

    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_UPDATE = 2'd1,
        FILL_NEW    = 2'd2,
        FILL_EVICT  = 2'd3
    } fill_kind_e;

endpackage

// File: rtl/pairq_match.sv
module pairq_match #(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 104
) (
    input  logic [ENTRIES-1:0][KEY_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valids,
    input  logic [KEY_W-1:0]              probe,
    output logic [ENTRIES-1:0]            hits
);

    // One full-width comparator per entry.
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign hits[i] = valids[i] && (tags[i] == probe);
        end
    endgenerate

endmodule

// File: rtl/pairq_encode.sv
module pairq_encode #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // OR-encoder: the input has at most one bit set.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/pairq_first_free.sv
module pairq_first_free #(
    parameter int N     = 128,
    parameter int IDX_W = 7
) (
    input  logic [N-1:0]     valids,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so that the lowest empty index is the last one written.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valids[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pairq_store.sv
module pairq_store #(
    parameter int ENTRIES = 128,
    parameter int KEY_W   = 104,
    parameter int DATA_W  = 55,
    parameter int IDX_W   = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_all,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [KEY_W-1:0]               wr_key,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [ENTRIES-1:0][KEY_W-1:0]  tags,
    output logic [ENTRIES-1:0][DATA_W-1:0] datas,
    output logic [ENTRIES-1:0]             valids
);

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            logic              sel;
            logic              vld_r;
            logic [KEY_W-1:0]  tag_r;
            logic [DATA_W-1:0] dat_r;

            assign sel = wr_en && (wr_idx == IDX_W'(i));

            // Only the valid bits are reset; key and data are qualified by them.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_r <= 1'b0;
                end else if (clr_all) begin
                    vld_r <= 1'b0;
                end else if (sel) begin
                    vld_r <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (sel) begin
                    tag_r <= wr_key;
                    dat_r <= wr_data;
                end
            end

            assign tags[i]   = tag_r;
            assign datas[i]  = dat_r;
            assign valids[i] = vld_r;
        end
    endgenerate

endmodule

// File: rtl/pairq_cache.sv
module pairq_cache
    import pairq_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int MANT_W  = 52,
    parameter int QUO_W   = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [MANT_W-1:0] lk_dividend,
    input  logic [MANT_W-1:0] lk_divisor,
    input  logic              fill_valid,
    input  logic [MANT_W-1:0] fill_dividend,
    input  logic [MANT_W-1:0] fill_divisor,
    input  logic [QUO_W-1:0]  fill_quot,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [QUO_W-1:0]  resp_quot
);

    localparam int KEY_W = 2 * MANT_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][KEY_W-1:0] tags;
    logic [ENTRIES-1:0][QUO_W-1:0] datas;
    logic [ENTRIES-1:0]            valids;
    logic [ENTRIES-1:0]            lk_hits;
    logic [ENTRIES-1:0]            fl_hits;
    logic [KEY_W-1:0]              lk_key;
    logic [KEY_W-1:0]              fl_key;
    logic [IDX_W-1:0]              lk_idx;
    logic [IDX_W-1:0]              fl_idx;
    logic [IDX_W-1:0]              free_idx;
    logic [IDX_W-1:0]              rr_ptr;
    logic [IDX_W-1:0]              wr_idx;
    logic                          lk_any;
    logic                          fl_any;
    logic                          free_any;
    logic                          wr_en;
    fill_kind_e                    fill_kind;
    rsp_state_e                    state;
    rsp_state_e                    state_nx;
    logic                          hit_q;
    logic [QUO_W-1:0]              quot_q;

    assign lk_key = {lk_dividend, lk_divisor};
    assign fl_key = {fill_dividend, fill_divisor};

    pairq_store #(
        .ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(QUO_W), .IDX_W(IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (flush),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_key  (fl_key),
        .wr_data (fill_quot),
        .tags    (tags),
        .datas   (datas),
        .valids  (valids)
    );

    pairq_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
        .tags(tags), .valids(valids), .probe(lk_key), .hits(lk_hits)
    );

    pairq_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_fl_match (
        .tags(tags), .valids(valids), .probe(fl_key), .hits(fl_hits)
    );

    pairq_encode #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_enc (
        .vec(lk_hits), .idx(lk_idx), .any(lk_any)
    );

    pairq_encode #(.N(ENTRIES), .IDX_W(IDX_W)) u_fl_enc (
        .vec(fl_hits), .idx(fl_idx), .any(fl_any)
    );

    pairq_first_free #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
        .valids(valids), .idx(free_idx), .any(free_any)
    );

    // Fill classification: flush wins, then in-place, then empty slot, then evict.
    always_comb begin
        if (!fill_valid || flush) begin
            fill_kind = FILL_NONE;
        end else if (fl_any) begin
            fill_kind = FILL_UPDATE;
        end else if (free_any) begin
            fill_kind = FILL_NEW;
        end else begin
            fill_kind = FILL_EVICT;
        end
    end

    always_comb begin
        wr_en  = 1'b1;
        wr_idx = rr_ptr;
        unique case (fill_kind)
            FILL_NONE:   wr_en  = 1'b0;
            FILL_UPDATE: wr_idx = fl_idx;
            FILL_NEW:    wr_idx = free_idx;
            FILL_EVICT:  wr_idx = rr_ptr;
        endcase
    end

    // Round-robin victim pointer; moves only when a valid entry is evicted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_kind == FILL_EVICT) begin
            rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Response state machine: state register.
    always_comb begin
        state_nx = lk_valid ? RSP_SHOW : RSP_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RSP_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Lookup result capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            quot_q <= '0;
        end else if (lk_valid) begin
            hit_q  <= lk_any && !flush;
            quot_q <= datas[lk_idx];
        end
    end

    // Response state machine: outputs.
    always_comb begin
        resp_valid = 1'b0;
        resp_hit   = 1'b0;
        resp_quot  = '0;
        unique case (state)
            RSP_IDLE: begin
                resp_valid = 1'b0;
            end
            RSP_SHOW: begin
                resp_valid = 1'b1;
                resp_hit   = hit_q;
                resp_quot  = hit_q ? quot_q : '0;
            end
        endcase
    end

endmodule

// File: rtl/pairq_cache_chk.sv
module pairq_cache_chk #(
    parameter int ENTRIES = 128,
    parameter int MANT_W  = 52,
    parameter int QUO_W   = 55
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               lk_valid,
    input logic [MANT_W-1:0]  lk_dividend,
    input logic [MANT_W-1:0]  lk_divisor,
    input logic               fill_valid,
    input logic [MANT_W-1:0]  fill_dividend,
    input logic [MANT_W-1:0]  fill_divisor,
    input logic [QUO_W-1:0]   fill_quot,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic [QUO_W-1:0]   resp_quot,
    input logic [ENTRIES-1:0] lk_hits
);

    p_answer_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> resp_valid);

    p_quiet_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !resp_valid);

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> (resp_quot == '0));

    p_no_hit_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_hit);

    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits));

    p_flush_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && lk_valid) |=> !resp_hit);

    p_flush_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lk_valid |=> !resp_hit);

    p_fill_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) ##1
        (lk_valid && !flush &&
         (lk_dividend == $past(fill_dividend)) && (lk_divisor == $past(fill_divisor)))
        |=> (resp_hit && (resp_quot == $past(fill_quot, 2))));

endmodule

bind pairq_cache pairq_cache_chk #(
    .ENTRIES(ENTRIES), .MANT_W(MANT_W), .QUO_W(QUO_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .lk_valid      (lk_valid),
    .lk_dividend   (lk_dividend),
    .lk_divisor    (lk_divisor),
    .fill_valid    (fill_valid),
    .fill_dividend (fill_dividend),
    .fill_divisor  (fill_divisor),
    .fill_quot     (fill_quot),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_quot     (resp_quot),
    .lk_hits       (lk_hits)
);

// File: tb/pairq_cache_test.sv
module pairq_cache_test;

    localparam int N  = 128;
    localparam int MW = 52;
    localparam int QW = 55;
    localparam int KW = 2 * MW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          lk_valid = 1'b0;
    logic [MW-1:0] lk_dividend = '0;
    logic [MW-1:0] lk_divisor = '0;
    logic          fill_valid = 1'b0;
    logic [MW-1:0] fill_dividend = '0;
    logic [MW-1:0] fill_divisor = '0;
    logic [QW-1:0] fill_quot = '0;
    logic          resp_valid;
    logic          resp_hit;
    logic [QW-1:0] resp_quot;

    always #5ns clk = ~clk;

    pairq_cache #(.ENTRIES(N), .MANT_W(MW), .QUO_W(QW)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_dividend(lk_dividend), .lk_divisor(lk_divisor),
        .fill_valid(fill_valid), .fill_dividend(fill_dividend),
        .fill_divisor(fill_divisor), .fill_quot(fill_quot),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_quot(resp_quot)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model built from the requirements.
    logic [KW-1:0] mk [N];
    logic [QW-1:0] mq [N];
    bit            mv [N];
    int            mptr = 0;

    bit            pend = 0;
    bit            exp_hit = 0;
    logic [QW-1:0] exp_q = '0;
    string         pend_tag = "";

    function automatic logic [KW-1:0] key_of(input int fam, input int k);
        logic [MW-1:0] a;
        logic [MW-1:0] b;
        a = {4'(fam), 16'hA5C3, 32'(k)};
        b = {32'(k * 7 + 1), 4'(fam), 16'h3C5A};
        return {a, b};
    endfunction

    function automatic int model_find(input logic [KW-1:0] key);
        for (int i = 0; i < N; i++) begin
            if (mv[i] && mk[i] == key) return i;
        end
        return -1;
    endfunction

    function automatic void model_fill(input logic [KW-1:0] key, input logic [QW-1:0] q);
        int slot;
        slot = model_find(key);
        if (slot < 0) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!mv[i]) slot = i;
            end
        end
        if (slot < 0) begin
            slot = mptr;
            mptr = (mptr + 1) % N;
        end
        mk[slot] = key;
        mq[slot] = q;
        mv[slot] = 1'b1;
    endfunction

    task automatic check_resp();
        checks++;
        if (pend) begin
            if (!(resp_valid === 1'b1 && resp_hit === exp_hit && resp_quot === exp_q)) begin
                failures++;
                $display("FAIL %s: got v=%0b h=%0b q=%h expected v=1 h=%0b q=%h",
                         pend_tag, resp_valid, resp_hit, resp_quot, exp_hit, exp_q);
            end
        end else if (resp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: got v=%0b expected v=0 with no lookup", resp_valid);
        end
    endtask

    // Called at a falling edge; leaves the bench at the next falling edge.
    task automatic step(input bit lk, input logic [KW-1:0] lkey,
                        input bit fl, input logic [KW-1:0] fkey,
                        input logic [QW-1:0] fq, input bit fsh, input string tag);
        int slot;
        check_resp();
        pend = lk;
        pend_tag = tag;
        if (lk) begin
            slot = model_find(lkey);
            exp_hit = !fsh && (slot >= 0);
            exp_q = exp_hit ? mq[slot] : '0;
        end
        if (fsh) begin
            for (int i = 0; i < N; i++) mv[i] = 1'b0;
        end else if (fl) begin
            model_fill(fkey, fq);
        end
        lk_valid = lk;
        {lk_dividend, lk_divisor} = lkey;
        fill_valid = fl;
        {fill_dividend, fill_divisor} = fkey;
        fill_quot = fq;
        flush = fsh;
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [KW-1:0] k, input logic [QW-1:0] q, input string tag);
        step(0, '0, 1, k, q, 0, tag);
    endtask

    task automatic do_look(input logic [KW-1:0] k, input string tag);
        step(1, k, 0, '0, '0, 0, tag);
    endtask

    function automatic logic [QW-1:0] qval(input int a, input int b);
        return {7'(a), 16'(b * 31 + 5), 32'(a * 977 + b)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [KW-1:0] k1;
        logic [KW-1:0] k2;
        logic [KW-1:0] kx;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) mv[i] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: empty after reset, no answer pending.
        do_look(key_of(1, 1), "R9");
        do_look(key_of(1, 2), "R9");

        // R4: a fill is seen by the next lookup but not by a lookup in its own cycle.
        k1 = key_of(2, 10);
        k2 = key_of(2, 11);
        step(1, k1, 1, k1, qval(1, 1), 0, "R4 same-cycle");
        do_look(k1, "R4 next-cycle");
        do_look(k1, "R2 exact pair");

        // R2: a match on one operand only is a miss.
        kx = {k1[KW-1:MW], k2[MW-1:0]};
        do_look(kx, "R2 dividend only");
        kx = {k2[KW-1:MW], k1[MW-1:0]};
        do_look(kx, "R2 divisor only");
        do_look(k2, "R3 miss zero");

        // R5: a fill with an existing key rewrites in place.
        do_fill(k1, qval(1, 2), "R5");
        do_look(k1, "R5 rewrite");

        // R8: flush beats a fill in the same cycle; lookups around the flush miss.
        step(1, k1, 1, k2, qval(2, 2), 1, "R8 same-cycle");
        do_look(k1, "R8 after flush");
        do_look(k2, "R8 fill dropped");

        // R6/R7: fill up, then evict twice from the pointer start.
        for (int i = 0; i < N; i++) do_fill(key_of(3, i), qval(3, i), "R6");
        do_look(key_of(3, 0), "R6 first");
        do_look(key_of(3, N - 1), "R6 last");
        do_fill(key_of(4, 0), qval(4, 0), "R7");
        do_fill(key_of(4, 1), qval(4, 1), "R7");
        do_look(key_of(3, 0), "R7 victim 0");
        do_look(key_of(3, 1), "R7 victim 1");
        do_look(key_of(3, 2), "R7 survivor");

        // R6/R7: after a flush, empty entries fill in order and the pointer keeps its place.
        step(0, '0, 0, '0, '0, 1, "R8");
        for (int i = 0; i < N; i++) do_fill(key_of(5, i), qval(5, i), "R6");
        do_fill(key_of(5, 1), qval(5, 99), "R5 no pointer move");
        do_fill(key_of(6, 0), qval(6, 0), "R7");
        do_look(key_of(5, 0), "R6 kept 0");
        do_look(key_of(5, 1), "R5 kept rewritten");
        do_look(key_of(5, 2), "R7 victim after flush");
        do_look(key_of(6, 0), "R7 newcomer");

        // Random mix over a key pool larger than the cache.
        for (int c = 0; c < 4000; c++) begin
            int r;
            bit lk;
            bit fl;
            bit fs;
            logic [QW-1:0] q;
            r  = $urandom_range(0, 999);
            fs = (r < 8);
            lk = ($urandom_range(0, 99) < 70);
            fl = ($urandom_range(0, 99) < 45);
            q  = {$urandom, $urandom};
            step(lk, key_of(7, $urandom_range(0, 299)),
                 fl, key_of(7, $urandom_range(0, 299)), q, fs, "R2 R7 random");
        end

        step(0, '0, 0, '0, '0, 0, "R1");
        check_resp();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule